// File: doc/BRIEF.md
# Write-Through Write-Update Snooping Data Cache

This block is a small direct-mapped data cache that sits between one in-order core and a shared broadcast bus. Each line holds a single word and has only two states, invalid and valid. A load that finds its line valid with a matching tag completes in the cycle it is presented. A load that misses asks the bus arbiter for a grant, sends a read, waits for the memory response, installs the word and hands it to the core. A store is never written into the array directly. It always asks for the bus, drives the write during its grant cycle and holds the core until the write comes back on the snoop port.

The snoop port shows every bus transaction from every agent, including this cache's own writes. The bus fabric presents a granted write on the snoop port in the cycle after the grant. Any snooped write whose address matches a valid line replaces that line's word. A write whose address is not resident is dropped, because the cache never allocates on a write. Memory stays current at all times, so no line is ever dirty and eviction needs no write-back.

A fill that is in flight also watches the snoop port for writes to its own address. The newest such value is installed and returned in place of the possibly stale memory word.

Top module: `wtu_snoop_cache`

## Requirements
- R1: After reset every line is invalid, and `core_done`, `bus_req` and `bus_out_valid` are low. The first load to any address therefore misses.
- R2: A load whose line is valid with a matching tag raises `core_done` in the same cycle as `core_req`, with the word on `core_rdata`, and causes no bus transaction.
- R3: A load miss holds `bus_req` until `bus_gnt`. In the grant cycle it drives `bus_out_valid` with `bus_out_we`=0 and the load address. It raises `core_done` with the word in the cycle `mem_rvalid` is high. The line is then valid, so a repeat load hits.
- R4: Every store goes to the bus, whether or not its line is resident. `bus_req` is held until `bus_gnt`. In the grant cycle the cache drives `bus_out_we`=1 with the core's address and data. `core_done` rises exactly one cycle after the grant cycle and never earlier.
- R5: The cache updates its own copy for a store only from the data seen on the snoop port one cycle after the grant, not from `core_wdata`.
- R6: A snooped write (`snp_valid`=1, `snp_we`=1) to an address held in a valid line replaces that line's word. A later load to that address hits and returns the new word.
- R7: A snooped write to an address that is not resident (line invalid, or a different tag at that index) allocates nothing and leaves the resident line at that index untouched.
- R8: A store to a non-resident address does not allocate, so a later load to that address misses.
- R9: A snooped write to the address of an in-flight fill, seen after the read was granted and before `mem_rvalid`, determines the installed and returned word in place of `mem_rdata`.
- R10: A snooped write to the fill address in the same cycle as `mem_rvalid` takes priority over `mem_rdata`.
- R11: A snooped read (`snp_valid`=1, `snp_we`=0) changes no cached word.
- R12: `bus_out_valid` is high only in a cycle where both `bus_req` and `bus_gnt` are high, and for one cycle per operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| core_req | input | 1 | Core operation request, held until `core_done` |
| core_we | input | 1 | 1 = store, 0 = load |
| core_addr | input | AW | Word address |
| core_wdata | input | DW | Store data |
| core_done | output | 1 | Operation complete, one cycle |
| core_rdata | output | DW | Load data, valid with `core_done` |
| bus_req | output | 1 | Bus arbitration request |
| bus_gnt | input | 1 | Bus grant for this cycle |
| bus_out_valid | output | 1 | This cache drives the bus this cycle |
| bus_out_we | output | 1 | Driven transaction is a write |
| bus_out_addr | output | AW | Driven address |
| bus_out_data | output | DW | Driven write data |
| snp_valid | input | 1 | A bus transaction is visible to snoopers |
| snp_we | input | 1 | Snooped transaction is a write |
| snp_addr | input | AW | Snooped address |
| snp_data | input | DW | Snooped write data |
| mem_rvalid | input | 1 | Memory read response for this cache |
| mem_rdata | input | DW | Memory read data |

## Verification
A corrupted tag or valid bit shows up at the ports on the next load to the affected address. Either bus traffic appears where a hit was due, or no bus traffic appears and the wrong word is returned. A missed or misapplied snoop update stays hidden until the core next reads that address, so every snoop scenario is followed at once by a load that must hit and return the expected word. A wrong fill merge shows in the very cycle `core_done` rises, as a stale `mem_rdata` value. It is then confirmed by the next hit.

// File: rtl/wtu_pkg.sv
// Shared types for the write-through write-update snooping cache.
package wtu_pkg;

    // Controller states; one bus operation at most is outstanding.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_REQ,
        ST_RD_WAIT,
        ST_WR_REQ,
        ST_WR_ECHO
    } wtu_state_e;

endpackage

// File: rtl/wtu_line_store.sv
// Line storage: LINES one-word lines, each with a valid bit and a tag.
// Assumes: LINES is a power of two, and IDX_W equals $clog2(LINES).
// Two read ports: one for core lookup, one for snoop tag compare.
// Two write ports: fill (sets valid, tag, data) and update (data only).
// The caller keeps fill and update off the same line in one cycle.
module wtu_line_store #(
    parameter int LINES = 16,
    parameter int IDX_W = 4,
    parameter int TAG_W = 12,
    parameter int DW    = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] look_idx,
    output logic             look_v,
    output logic [TAG_W-1:0] look_tag,
    output logic [DW-1:0]    look_data,
    input  logic [IDX_W-1:0] snp_idx,
    output logic             snp_v,
    output logic [TAG_W-1:0] snp_tag,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic [DW-1:0]    fill_data,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic [DW-1:0]    upd_data
);

    logic             line_v    [LINES];
    logic [TAG_W-1:0] line_tag  [LINES];
    logic [DW-1:0]    line_data [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic             v_q;
        logic [TAG_W-1:0] t_q;
        logic [DW-1:0]    d_q;
        logic             fill_me;
        logic             upd_me;

        assign fill_me = fill_en && (fill_idx == IDX_W'(g));
        assign upd_me  = upd_en  && (upd_idx  == IDX_W'(g));

        // Hold one line; a fill installs it, an update rewrites its word.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v_q <= 1'b0;
                t_q <= '0;
                d_q <= '0;
            end else begin
                if (fill_me) begin
                    v_q <= 1'b1;
                    t_q <= fill_tag;
                    d_q <= fill_data;
                end
                if (upd_me) begin
                    d_q <= upd_data;
                end
            end
        end

        assign line_v[g]    = v_q;
        assign line_tag[g]  = t_q;
        assign line_data[g] = d_q;
    end

    assign look_v    = line_v[look_idx];
    assign look_tag  = line_tag[look_idx];
    assign look_data = line_data[look_idx];
    assign snp_v     = line_v[snp_idx];
    assign snp_tag   = line_tag[snp_idx];

endmodule

// File: rtl/wtu_fill_merge.sv
// Fill merge: tracks snooped writes to the address of an in-flight fill.
// The newest one replaces the memory response.
// Assumes: clear is high while the read waits for a grant, and watch is
// high from the cycle after the grant up to and including the response.
module wtu_fill_merge #(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          watch,
    input  logic [AW-1:0] tgt_addr,
    input  logic          snp_valid,
    input  logic          snp_we,
    input  logic [AW-1:0] snp_addr,
    input  logic [DW-1:0] snp_data,
    input  logic [DW-1:0] mem_rdata,
    output logic [DW-1:0] merged
);

    logic          same_now;
    logic          pend_v;
    logic [DW-1:0] pend_d;

    assign same_now = snp_valid && snp_we && (snp_addr == tgt_addr);

    // Remember the latest snooped write to the fill address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_v <= 1'b0;
            pend_d <= '0;
        end else if (clear) begin
            pend_v <= 1'b0;
        end else if (watch && same_now) begin
            pend_v <= 1'b1;
            pend_d <= snp_data;
        end
    end

    // Choose the newest value: this cycle's snoop, then a stored one, then memory.
    always_comb begin
        if (watch && same_now) begin
            merged = snp_data;
        end else if (pend_v) begin
            merged = pend_d;
        end else begin
            merged = mem_rdata;
        end
    end

endmodule

// File: rtl/wtu_ctrl.sv
// Controller: sequences core loads and stores onto the bus.
// Assumes: the core holds core_req until core_done and then drops it or
// presents its next operation; a granted write reappears on the snoop
// port exactly one cycle after the grant.
module wtu_ctrl
    import wtu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic core_req,
    input  logic core_we,
    input  logic look_hit,
    input  logic bus_gnt,
    input  logic mem_rvalid,
    output logic bus_req,
    output logic drive,
    output logic drive_we,
    output logic core_done,
    output logic take_req,
    output logic fill_en,
    output logic fill_wait,
    output logic wait_clear
);

    wtu_state_e state_q;
    wtu_state_e state_d;

    // Next state and per-state outputs.
    always_comb begin
        state_d   = state_q;
        bus_req   = 1'b0;
        drive     = 1'b0;
        drive_we  = 1'b0;
        core_done = 1'b0;
        take_req  = 1'b0;
        fill_en   = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (core_req) begin
                    if (core_we) begin
                        take_req = 1'b1;
                        state_d  = ST_WR_REQ;
                    end else if (look_hit) begin
                        core_done = 1'b1;
                    end else begin
                        take_req = 1'b1;
                        state_d  = ST_RD_REQ;
                    end
                end
            end
            ST_RD_REQ: begin
                bus_req = 1'b1;
                if (bus_gnt) begin
                    drive   = 1'b1;
                    state_d = ST_RD_WAIT;
                end
            end
            ST_RD_WAIT: begin
                if (mem_rvalid) begin
                    fill_en   = 1'b1;
                    core_done = 1'b1;
                    state_d   = ST_IDLE;
                end
            end
            ST_WR_REQ: begin
                bus_req = 1'b1;
                if (bus_gnt) begin
                    drive    = 1'b1;
                    drive_we = 1'b1;
                    state_d  = ST_WR_ECHO;
                end
            end
            ST_WR_ECHO: begin
                core_done = 1'b1;
                state_d   = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign fill_wait  = (state_q == ST_RD_WAIT);
    assign wait_clear = (state_q == ST_RD_REQ);

endmodule

// File: rtl/wtu_snoop_cache.sv
// Top: direct-mapped, one word per line, write-through with write-update
// snooping. Every store goes to the bus. All cached copies, including this
// one, change only when a write is seen on the snoop port.
// Assumes: LINES is a power of two, at least 2, and smaller than 2**AW.
module wtu_snoop_cache #(
    parameter int AW    = 16,
    parameter int DW    = 32,
    parameter int LINES = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          core_req,
    input  logic          core_we,
    input  logic [AW-1:0] core_addr,
    input  logic [DW-1:0] core_wdata,
    output logic          core_done,
    output logic [DW-1:0] core_rdata,
    output logic          bus_req,
    input  logic          bus_gnt,
    output logic          bus_out_valid,
    output logic          bus_out_we,
    output logic [AW-1:0] bus_out_addr,
    output logic [DW-1:0] bus_out_data,
    input  logic          snp_valid,
    input  logic          snp_we,
    input  logic [AW-1:0] snp_addr,
    input  logic [DW-1:0] snp_data,
    input  logic          mem_rvalid,
    input  logic [DW-1:0] mem_rdata
);

    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = AW - IDX_W;

    logic [AW-1:0]    req_addr_q;
    logic [DW-1:0]    req_data_q;
    logic             look_v;
    logic [TAG_W-1:0] look_tag;
    logic [DW-1:0]    look_data;
    logic             look_hit;
    logic             snp_v;
    logic [TAG_W-1:0] snp_tag;
    logic             snp_line_hit;
    logic             upd_en;
    logic             take_req;
    logic             fill_en;
    logic             fill_wait;
    logic             wait_clear;
    logic             drive;
    logic             drive_we;
    logic [DW-1:0]    merged;

    // Capture the operation handed to the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_addr_q <= '0;
            req_data_q <= '0;
        end else if (take_req) begin
            req_addr_q <= core_addr;
            req_data_q <= core_wdata;
        end
    end

    assign look_hit = look_v && (look_tag == core_addr[AW-1:IDX_W]);

    // A snooped write touches only a resident line. A line that is being
    // refilled this cycle belongs to the new address, which the merge covers.
    assign snp_line_hit = snp_valid && snp_we && snp_v
                          && (snp_tag == snp_addr[AW-1:IDX_W]);
    assign upd_en = snp_line_hit
                    && !(fill_en && (req_addr_q[IDX_W-1:0] == snp_addr[IDX_W-1:0]));

    wtu_line_store #(
        .LINES (LINES),
        .IDX_W (IDX_W),
        .TAG_W (TAG_W),
        .DW    (DW)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .look_idx  (core_addr[IDX_W-1:0]),
        .look_v    (look_v),
        .look_tag  (look_tag),
        .look_data (look_data),
        .snp_idx   (snp_addr[IDX_W-1:0]),
        .snp_v     (snp_v),
        .snp_tag   (snp_tag),
        .fill_en   (fill_en),
        .fill_idx  (req_addr_q[IDX_W-1:0]),
        .fill_tag  (req_addr_q[AW-1:IDX_W]),
        .fill_data (merged),
        .upd_en    (upd_en),
        .upd_idx   (snp_addr[IDX_W-1:0]),
        .upd_data  (snp_data)
    );

    wtu_fill_merge #(
        .AW (AW),
        .DW (DW)
    ) u_merge (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (wait_clear),
        .watch     (fill_wait),
        .tgt_addr  (req_addr_q),
        .snp_valid (snp_valid),
        .snp_we    (snp_we),
        .snp_addr  (snp_addr),
        .snp_data  (snp_data),
        .mem_rdata (mem_rdata),
        .merged    (merged)
    );

    wtu_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .core_req   (core_req),
        .core_we    (core_we),
        .look_hit   (look_hit),
        .bus_gnt    (bus_gnt),
        .mem_rvalid (mem_rvalid),
        .bus_req    (bus_req),
        .drive      (drive),
        .drive_we   (drive_we),
        .core_done  (core_done),
        .take_req   (take_req),
        .fill_en    (fill_en),
        .fill_wait  (fill_wait),
        .wait_clear (wait_clear)
    );

    assign bus_out_valid = drive;
    assign bus_out_we    = drive_we;
    assign bus_out_addr  = req_addr_q;
    assign bus_out_data  = req_data_q;
    assign core_rdata    = fill_wait ? merged : look_data;

endmodule

// File: rtl/wtu_snoop_cache_chk.sv
// Checker: bus protocol and completion timing of wtu_snoop_cache.
module wtu_snoop_cache_chk (
    input logic clk,
    input logic rst_n,
    input logic core_done,
    input logic bus_req,
    input logic bus_gnt,
    input logic bus_out_valid,
    input logic bus_out_we,
    input logic mem_rvalid,
    input logic fill_wait
);

    assert_drive_needs_grant_R12: assert property (@(posedge clk) disable iff (!rst_n)
        bus_out_valid |-> (bus_req && bus_gnt));

    assert_single_drive_R12: assert property (@(posedge clk) disable iff (!rst_n)
        bus_out_valid |=> !bus_out_valid);

    assert_req_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt) |=> bus_req);

    assert_store_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_out_valid && bus_out_we) |=> core_done);

    assert_fill_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_wait && mem_rvalid) |-> core_done);

endmodule

bind wtu_snoop_cache wtu_snoop_cache_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .core_done     (core_done),
    .bus_req       (bus_req),
    .bus_gnt       (bus_gnt),
    .bus_out_valid (bus_out_valid),
    .bus_out_we    (bus_out_we),
    .mem_rvalid    (mem_rvalid),
    .fill_wait     (fill_wait)
);

// File: tb/wtu_snoop_cache_tb.sv
// Directed bench: bus model with arbiter, write echo and memory; one task per scenario.
module wtu_snoop_cache_tb;

    localparam int MEM_LAT = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        core_req = 1'b0;
    logic        core_we = 1'b0;
    logic [15:0] core_addr = '0;
    logic [31:0] core_wdata = '0;
    logic        core_done;
    logic [31:0] core_rdata;
    logic        bus_req;
    logic        bus_gnt;
    logic        bus_out_valid;
    logic        bus_out_we;
    logic [15:0] bus_out_addr;
    logic [31:0] bus_out_data;
    logic        snp_valid = 1'b0;
    logic        snp_we = 1'b0;
    logic [15:0] snp_addr = '0;
    logic [31:0] snp_data = '0;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;

    logic        gnt_en = 1'b1;
    logic [31:0] echo_xor = '0;
    logic        rem_go = 1'b0;
    logic        rem_we = 1'b0;
    logic [15:0] rem_addr = '0;
    logic [31:0] rem_data = '0;
    logic [31:0] mem [256];
    logic [31:0] rd_q = '0;
    int          rd_cnt = 0;
    int          bus_ops = 0;
    int          grant_viol = 0;
    logic [15:0] last_addr = '0;
    logic [31:0] last_data = '0;
    logic        last_we = 1'b0;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    assign bus_gnt = bus_req && gnt_en;

    wtu_snoop_cache u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .core_req      (core_req),
        .core_we       (core_we),
        .core_addr     (core_addr),
        .core_wdata    (core_wdata),
        .core_done     (core_done),
        .core_rdata    (core_rdata),
        .bus_req       (bus_req),
        .bus_gnt       (bus_gnt),
        .bus_out_valid (bus_out_valid),
        .bus_out_we    (bus_out_we),
        .bus_out_addr  (bus_out_addr),
        .bus_out_data  (bus_out_data),
        .snp_valid     (snp_valid),
        .snp_we        (snp_we),
        .snp_addr      (snp_addr),
        .snp_data      (snp_data),
        .mem_rvalid    (mem_rvalid),
        .mem_rdata     (mem_rdata)
    );

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'hC0DE_0000 | i;
    end

    // Bus model: echo own writes, inject remote traffic, answer reads with latency.
    always @(posedge clk) begin
        snp_valid <= 1'b0;
        snp_we    <= 1'b0;
        if (bus_out_valid) begin
            bus_ops   <= bus_ops + 1;
            last_addr <= bus_out_addr;
            last_data <= bus_out_data;
            last_we   <= bus_out_we;
            if (!bus_gnt) grant_viol <= grant_viol + 1;
        end
        if (bus_out_valid && bus_out_we) begin
            mem[bus_out_addr[7:0]] <= bus_out_data ^ echo_xor;
            snp_valid <= 1'b1;
            snp_we    <= 1'b1;
            snp_addr  <= bus_out_addr;
            snp_data  <= bus_out_data ^ echo_xor;
        end else if (rem_go) begin
            if (rem_we) mem[rem_addr[7:0]] <= rem_data;
            snp_valid <= 1'b1;
            snp_we    <= rem_we;
            snp_addr  <= rem_addr;
            snp_data  <= rem_data;
        end
        if (bus_out_valid && !bus_out_we) begin
            rd_cnt <= MEM_LAT;
            rd_q   <= mem[bus_out_addr[7:0]];
        end else if (rd_cnt != 0) begin
            rd_cnt <= rd_cnt - 1;
        end
        mem_rvalid <= (rd_cnt == 1);
        mem_rdata  <= rd_q;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_op(input logic we, input logic [15:0] a, input logic [31:0] d,
                         output logic [31:0] rd, output int ops, output int waits);
        int start_ops;
        @(negedge clk);
        start_ops  = bus_ops;
        core_req   = 1'b1;
        core_we    = we;
        core_addr  = a;
        core_wdata = d;
        #1;
        waits = 0;
        while (!core_done && waits < 80) begin
            @(negedge clk);
            #1;
            waits++;
        end
        rd       = core_rdata;
        core_req = 1'b0;
        core_we  = 1'b0;
        ops      = bus_ops - start_ops;
    endtask

    task automatic remote(input logic we, input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        rem_go   = 1'b1;
        rem_we   = we;
        rem_addr = a;
        rem_data = d;
        @(negedge clk);
        rem_go = 1'b0;
    endtask

    task automatic t_reset_and_hit();
        logic [31:0] rd;
        int ops, w;
        chk("R1 done low", 32'(core_done), 32'd0);
        chk("R1 bus_req low", 32'(bus_req), 32'd0);
        chk("R1 drive low", 32'(bus_out_valid), 32'd0);
        do_op(1'b0, 16'h0010, '0, rd, ops, w);
        chk("R1 first load misses", 32'(ops), 32'd1);
        chk("R3 miss data", rd, 32'hC0DE_0010);
        do_op(1'b0, 16'h0010, '0, rd, ops, w);
        chk("R2 hit no bus", 32'(ops), 32'd0);
        chk("R2 hit same cycle", 32'(w), 32'd0);
        chk("R2 hit data", rd, 32'hC0DE_0010);
    endtask

    task automatic t_miss_stall();
        logic [31:0] rd;
        int ops, w;
        gnt_en = 1'b0;
        fork
            do_op(1'b0, 16'h0021, '0, rd, ops, w);
            begin
                repeat (4) @(negedge clk);
                #2;
                chk("R3 req held", 32'(bus_req), 32'd1);
                chk("R3 no early done", 32'(core_done), 32'd0);
                gnt_en = 1'b1;
            end
        join
        chk("R3 stalled miss data", rd, 32'hC0DE_0021);
        chk("R3 read addr", 32'(last_addr), 32'h0021);
        chk("R3 read not write", 32'(last_we), 32'd0);
        do_op(1'b0, 16'h0021, '0, rd, ops, w);
        chk("R3 line now valid", 32'(ops), 32'd0);
    endtask

    task automatic t_store_echo();
        logic [31:0] rd;
        int ops, w;
        do_op(1'b0, 16'h0022, '0, rd, ops, w);
        echo_xor = 32'h0000_FFFF;
        gnt_en = 1'b0;
        fork
            do_op(1'b1, 16'h0022, 32'h1111_0000, rd, ops, w);
            begin
                repeat (4) @(negedge clk);
                #2;
                gnt_en = 1'b1;
            end
        join
        echo_xor = '0;
        chk("R4 done one cycle after grant", 32'(w), 32'd4);
        chk("R4 store on bus", 32'(ops), 32'd1);
        chk("R4 write flag", 32'(last_we), 32'd1);
        chk("R4 write addr", 32'(last_addr), 32'h0022);
        chk("R4 write data", last_data, 32'h1111_0000);
        do_op(1'b0, 16'h0022, '0, rd, ops, w);
        chk("R5 hit after store", 32'(ops), 32'd0);
        chk("R5 copy from bus echo", rd, 32'h1111_FFFF);
    endtask

    task automatic t_snoop_update();
        logic [31:0] rd;
        int ops, w;
        do_op(1'b0, 16'h0045, '0, rd, ops, w);
        remote(1'b1, 16'h0045, 32'hDEAD_0045);
        do_op(1'b0, 16'h0045, '0, rd, ops, w);
        chk("R6 still hit", 32'(ops), 32'd0);
        chk("R6 updated word", rd, 32'hDEAD_0045);
        remote(1'b0, 16'h0045, 32'h1234_5678);
        do_op(1'b0, 16'h0045, '0, rd, ops, w);
        chk("R11 read snoop ignored", rd, 32'hDEAD_0045);
    endtask

    task automatic t_snoop_absent();
        logic [31:0] rd;
        int ops, w;
        remote(1'b1, 16'h0055, 32'h7777_0055);
        do_op(1'b0, 16'h0045, '0, rd, ops, w);
        chk("R7 resident line hits", 32'(ops), 32'd0);
        chk("R7 resident word kept", rd, 32'hDEAD_0045);
        do_op(1'b0, 16'h0055, '0, rd, ops, w);
        chk("R7 mismatch not allocated", 32'(ops), 32'd1);
        chk("R7 miss data", rd, 32'h7777_0055);
        remote(1'b1, 16'h000E, 32'h0E0E_0E0E);
        do_op(1'b0, 16'h000E, '0, rd, ops, w);
        chk("R7 invalid not allocated", 32'(ops), 32'd1);
        chk("R7 invalid miss data", rd, 32'h0E0E_0E0E);
    endtask

    task automatic t_no_alloc();
        logic [31:0] rd;
        int ops, w;
        do_op(1'b1, 16'h0066, 32'hABCD_0066, rd, ops, w);
        do_op(1'b0, 16'h0066, '0, rd, ops, w);
        chk("R8 store did not allocate", 32'(ops), 32'd1);
        chk("R8 data from memory", rd, 32'hABCD_0066);
    endtask

    task automatic t_fill_merge();
        logic [31:0] rd;
        int ops, w;
        fork
            do_op(1'b0, 16'h007A, '0, rd, ops, w);
            begin
                repeat (2) @(negedge clk);
                remote(1'b1, 16'h007A, 32'h5A5A_007A);
            end
        join
        chk("R9 returned newest", rd, 32'h5A5A_007A);
        do_op(1'b0, 16'h007A, '0, rd, ops, w);
        chk("R9 installed newest", rd, 32'h5A5A_007A);
    endtask

    task automatic t_fill_same_cycle();
        logic [31:0] rd;
        int ops, w;
        fork
            do_op(1'b0, 16'h008B, '0, rd, ops, w);
            begin
                repeat (4) @(negedge clk);
                remote(1'b1, 16'h008B, 32'h600D_008B);
            end
        join
        chk("R10 snoop wins returned", rd, 32'h600D_008B);
        do_op(1'b0, 16'h008B, '0, rd, ops, w);
        chk("R10 snoop wins installed", rd, 32'h600D_008B);
        chk("R10 hit", 32'(ops), 32'd0);
    endtask

    initial begin
        #(20 * 100000);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        t_reset_and_hit();
        t_miss_stall();
        t_store_echo();
        t_snoop_update();
        t_snoop_absent();
        t_no_alloc();
        t_fill_merge();
        t_fill_same_cycle();
        chk("R12 drive only when granted", 32'(grant_viol), 32'd0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule